// File: doc/BRIEF.md
# Fan Fail-Safe Power-On Sequencer

This block decides what the cooling fans do between power-up and the moment the host takes control of a thermal fan controller. On its first clock after reset it checks a flag that says the processor core rail is above its power-good level (0.75 V, compared outside the block). If the rail is up, a fail-safe countdown of nominally 4.6 s starts. A valid serial-bus transaction addressed to the device before the countdown ends moves the block straight into normal operation with default register settings. If the countdown ends first, the fans are driven to full speed until the host finally addresses the device. Then the fans leave full speed and normal operation begins. If the rail is down at power-on, the block waits for the first transaction without a deadline. It starts the countdown if the rail comes up while it waits.

A strap selects the variant that spins the fans at full speed for the whole time before normal operation. The other variant holds them off until a timeout.

Separately, a second comparator flag reports that the core rail is under a programmable low limit, as happens in processor sleep states. While that flag is set, the block sets a sticky status bit, can raise an alert request, and removes the enables for thermal-input monitoring, the thermal event timer, dynamic minimum-temperature adjustment and shutdown entry. The timer enable is a count enable, so the timer keeps its value and is not cleared. Every enable returns once the rail is back above the limit.

Top module: `fan_failsafe_seq`

## Requirements
- R1: While reset is low, and in the single check cycle after it is released, the block shows the check state. In that state defaults_norm_o=0, fans_full_o equals spin_at_boot_i, fans_off_o is its inverse, low_rail_sts_o=0 and all four enables are 1.
- R2: With rail_good_i=1 at the check edge and no transaction, fans_full_o rises after clock edge TICKS+1 counted from reset release. TICKS = CLK_HZ*TIMEOUT_MS/1000.
- R3: A bus_hit_i pulse sampled at any edge from 2 to TICKS+1 after reset release, including the edge at which the countdown ends, sets defaults_norm_o after that edge. With spin_at_boot_i=0, fans_full_o never rises.
- R4: A bus_hit_i pulse while the fans are forced to full speed clears fans_full_o and sets defaults_norm_o after the same edge.
- R5: With rail_good_i=0 at the check edge, the block waits with no deadline and enters normal operation on the first bus_hit_i. If rail_good_i rises while it waits, the countdown of R2 starts at that edge and ends TICKS edges later. A transaction at that same edge takes priority.
- R6: With spin_at_boot_i=1, fans_full_o is 1 and fans_off_o is 0 in every state before normal operation. With spin_at_boot_i=0, fans_off_o is 1 in every such state except forced full speed.
- R7: fans_full_o and fans_off_o are never both 1. Both are 0 during normal operation.
- R8: Normal operation is kept until reset. Further bus_hit_i pulses and changes on rail_good_i have no effect on the fan outputs.
- R9: rail_low_i sampled at 1 sets low_rail_sts_o after that edge. The bit stays set until a status_clr_i pulse is sampled with rail_low_i=0. If set and clear arrive together, set wins.
- R10: alert_req_o is 1 exactly when low_rail_sts_o and alert_en_i are both 1, with no clock delay from alert_en_i.
- R11: therm_mon_en_o, therm_tmr_en_o, dyn_tmin_en_o and shutdown_en_o are 0 after an edge that samples rail_low_i=1 and are 1 after an edge that samples rail_low_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_good_i | input | 1 | Core rail above power-good level |
| rail_low_i | input | 1 | Core rail below programmable low limit |
| bus_hit_i | input | 1 | One-cycle pulse per valid addressed bus transaction |
| spin_at_boot_i | input | 1 | Variant strap: fans run before normal operation |
| alert_en_i | input | 1 | Enable for the low-rail alert request |
| status_clr_i | input | 1 | Clear pulse for the low-rail status bit |
| fans_full_o | output | 1 | Command fans to full speed |
| fans_off_o | output | 1 | Command fans off |
| defaults_norm_o | output | 1 | Defaults loaded, normal operation |
| low_rail_sts_o | output | 1 | Sticky low-rail status bit |
| alert_req_o | output | 1 | Alert request level |
| therm_mon_en_o | output | 1 | Thermal-input monitoring enable |
| therm_tmr_en_o | output | 1 | Thermal timer count enable (hold when 0) |
| dyn_tmin_en_o | output | 1 | Dynamic minimum-temperature adjustment enable |
| shutdown_en_o | output | 1 | Shutdown entry permitted |

## Verification
A corrupted sequencer state shows at the fan outputs after the next clock edge. The bench therefore compares fans_full_o, fans_off_o and defaults_norm_o at every cycle, sweeping every transaction arrival edge across the countdown for both straps. An off-by-one in the countdown moves the rise of fans_full_o by one edge, which the sweep sees at the boundary edge TICKS+1. A wrong low-rail register shows one edge after the rail flag changes. It appears on the enables and on the status bit, and through alert_en_i it appears on alert_req_o at once.

// File: rtl/fan_seq_pkg.sv
// Shared types for the fan fail-safe sequencer.
// Assumes: nothing beyond the synthesizable subset.
package fan_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_CHECK     = 3'd0,  // one-cycle power-on rail check
        SEQ_WAIT_UP   = 3'd1,  // rail up, countdown running
        SEQ_WAIT_DOWN = 3'd2,  // rail down, waiting for host
        SEQ_FORCED    = 3'd3,  // countdown ended, fans full
        SEQ_NORMAL    = 3'd4   // defaults loaded, host in control
    } seq_state_e;

endpackage

// File: rtl/fs_countdown.sv
// Fail-safe countdown. Holds the reload value while run is low, and counts
// down while run is high. done is high during the last counting cycle, so
// run stays high for exactly TICKS cycles before done.
// Assumes: TICKS >= 2.
module fs_countdown #(
    parameter longint unsigned TICKS = 64'd20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(TICKS + 64'd1);
    localparam logic [CW-1:0] RELOAD = CW'(TICKS - 64'd1);

    logic [CW-1:0] cnt;

    // Reload while idle, count down while running, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= RELOAD;
        end else if (!run) begin
            cnt <= RELOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    // Expiry flag for the sequencer.
    always_comb done = run && (cnt == '0);

endmodule

// File: rtl/fs_boot_fsm.sv
// Power-on sequencer. It checks the core rail once after reset and then
// waits for the host, with or without a deadline. It forces the fans to
// full speed when the deadline passes and enters normal operation on the
// first addressed transaction. Fan commands are decoded from the state and
// the variant strap.
// Assumes: bus_hit is a one-cycle pulse; timer_done comes from fs_countdown.
module fs_boot_fsm
    import fan_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rail_good,
    input  logic bus_hit,
    input  logic spin_strap,
    input  logic timer_done,
    output logic timer_run,
    output logic fans_full,
    output logic fans_off,
    output logic norm
);
    seq_state_e state, state_nxt;
    logic       pre_normal;

    // State register, back to the rail check on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_CHECK;
        else        state <= state_nxt;
    end

    // Next state: a transaction beats both the timeout and the rail rising.
    always_comb begin
        state_nxt = state;
        case (state)
            SEQ_CHECK:     state_nxt = rail_good ? SEQ_WAIT_UP : SEQ_WAIT_DOWN;
            SEQ_WAIT_UP:   if (bus_hit)         state_nxt = SEQ_NORMAL;
                           else if (timer_done) state_nxt = SEQ_FORCED;
            SEQ_WAIT_DOWN: if (bus_hit)        state_nxt = SEQ_NORMAL;
                           else if (rail_good) state_nxt = SEQ_WAIT_UP;
            SEQ_FORCED:    if (bus_hit)        state_nxt = SEQ_NORMAL;
            SEQ_NORMAL:    state_nxt = SEQ_NORMAL;
            default:       state_nxt = SEQ_CHECK;
        endcase
    end

    // Output decode for the fan commands and the countdown.
    always_comb begin
        pre_normal = (state == SEQ_CHECK) || (state == SEQ_WAIT_UP) ||
                     (state == SEQ_WAIT_DOWN);
        timer_run  = (state == SEQ_WAIT_UP);
        fans_full  = (state == SEQ_FORCED) || (pre_normal && spin_strap);
        fans_off   = pre_normal && !spin_strap;
        norm       = (state == SEQ_NORMAL);
    end

endmodule

// File: rtl/fs_lowrail_guard.sv
// Low-rail guard. Keeps a sticky status bit for the core rail being under its
// low limit, gates the alert request with its enable, and removes the thermal
// monitoring enables while the rail is low. The timer enable is a count
// enable, so the timer keeps its value.
// Assumes: rail_low is already synchronous to clk.
module fs_lowrail_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_low,
    input  logic alert_en,
    input  logic sts_clr,
    output logic sts,
    output logic alert_req,
    output logic mon_en,
    output logic tmr_en,
    output logic tmin_en,
    output logic shdn_en
);
    logic low_q;

    // Sticky status: a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        sts <= 1'b0;
        else if (rail_low) sts <= 1'b1;
        else if (sts_clr)  sts <= 1'b0;
    end

    // Registered copy of the low-rail flag that drives the enables.
    always_ff @(posedge clk) begin
        if (!rst_n) low_q <= 1'b0;
        else        low_q <= rail_low;
    end

    // Enables and alert level.
    always_comb begin
        mon_en    = !low_q;
        tmr_en    = !low_q;
        tmin_en   = !low_q;
        shdn_en   = !low_q;
        alert_req = sts && alert_en;
    end

endmodule

// File: rtl/fan_failsafe_seq.sv
// Top of the fan fail-safe sequencer. It joins the countdown, the power-on
// sequencer and the low-rail guard. The timeout in cycles comes from the
// clock frequency and the timeout in milliseconds.
// Assumes: all inputs synchronous to clk; CLK_HZ*TIMEOUT_MS/1000 >= 2.
module fan_failsafe_seq #(
    parameter int unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned TIMEOUT_MS = 4600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_good_i,
    input  logic rail_low_i,
    input  logic bus_hit_i,
    input  logic spin_at_boot_i,
    input  logic alert_en_i,
    input  logic status_clr_i,
    output logic fans_full_o,
    output logic fans_off_o,
    output logic defaults_norm_o,
    output logic low_rail_sts_o,
    output logic alert_req_o,
    output logic therm_mon_en_o,
    output logic therm_tmr_en_o,
    output logic dyn_tmin_en_o,
    output logic shutdown_en_o
);
    localparam longint unsigned TICKS =
        (64'(CLK_HZ) * 64'(TIMEOUT_MS)) / 64'd1000;

    logic t_run;
    logic t_done;

    fs_countdown #(.TICKS(TICKS)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (t_run),
        .done  (t_done)
    );

    fs_boot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rail_good  (rail_good_i),
        .bus_hit    (bus_hit_i),
        .spin_strap (spin_at_boot_i),
        .timer_done (t_done),
        .timer_run  (t_run),
        .fans_full  (fans_full_o),
        .fans_off   (fans_off_o),
        .norm       (defaults_norm_o)
    );

    fs_lowrail_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .rail_low  (rail_low_i),
        .alert_en  (alert_en_i),
        .sts_clr   (status_clr_i),
        .sts       (low_rail_sts_o),
        .alert_req (alert_req_o),
        .mon_en    (therm_mon_en_o),
        .tmr_en    (therm_tmr_en_o),
        .tmin_en   (dyn_tmin_en_o),
        .shdn_en   (shutdown_en_o)
    );

endmodule

// File: rtl/fan_failsafe_seq_chk.sv
// Checker for fan_failsafe_seq, attached by bind. It watches only ports.
// Assumes: synchronous active-low reset on rst_n.
module fan_failsafe_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic rail_low_i,
    input logic bus_hit_i,
    input logic spin_at_boot_i,
    input logic alert_en_i,
    input logic status_clr_i,
    input logic fans_full_o,
    input logic fans_off_o,
    input logic defaults_norm_o,
    input logic low_rail_sts_o,
    input logic alert_req_o,
    input logic therm_mon_en_o,
    input logic therm_tmr_en_o,
    input logic dyn_tmin_en_o,
    input logic shutdown_en_o
);
    a_r7_fans_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fans_full_o && fans_off_o));

    a_r8_normal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        defaults_norm_o |=> defaults_norm_o && !fans_full_o && !fans_off_o);

    a_r4_forced_release: assert property (@(posedge clk) disable iff (!rst_n)
        (fans_full_o && !spin_at_boot_i && bus_hit_i) |=>
            (defaults_norm_o && !fans_full_o));

    a_r6_strap_no_off: assert property (@(posedge clk) disable iff (!rst_n)
        spin_at_boot_i |-> !fans_off_o);

    a_r9_status_set: assert property (@(posedge clk) disable iff (!rst_n)
        rail_low_i |=> low_rail_sts_o);

    a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (low_rail_sts_o && !status_clr_i) |=> low_rail_sts_o);

    a_r10_alert_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_en_i |-> !alert_req_o);

    a_r11_low_disables: assert property (@(posedge clk) disable iff (!rst_n)
        rail_low_i |=> !therm_mon_en_o && !therm_tmr_en_o &&
                       !dyn_tmin_en_o && !shutdown_en_o);

    a_r11_high_enables: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_low_i |=> therm_mon_en_o && therm_tmr_en_o &&
                        dyn_tmin_en_o && shutdown_en_o);

endmodule

bind fan_failsafe_seq fan_failsafe_seq_chk u_chk (.*);

// File: tb/fan_failsafe_seq_tb.sv
// Bench for fan_failsafe_seq with a 20-cycle countdown. It sweeps every
// transaction edge for both straps, the rail-down path, and a mixed
// low-rail sequence against an arithmetic model.
module fan_failsafe_seq_tb;
    localparam int unsigned HZ = 10_000;
    localparam int unsigned MS = 2;
    localparam int T = 20;  // HZ*MS/1000

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rail_good = 1'b0, rail_low = 1'b0, bus_hit = 1'b0;
    logic strap = 1'b0, alert_en = 1'b0, sclr = 1'b0;
    logic full, off, norm, sts, alrt, mon, tmr, tmin, shdn;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fan_failsafe_seq #(.CLK_HZ(HZ), .TIMEOUT_MS(MS)) u_dut (
        .clk(clk), .rst_n(rst_n), .rail_good_i(rail_good), .rail_low_i(rail_low),
        .bus_hit_i(bus_hit), .spin_at_boot_i(strap), .alert_en_i(alert_en),
        .status_clr_i(sclr), .fans_full_o(full), .fans_off_o(off),
        .defaults_norm_o(norm), .low_rail_sts_o(sts), .alert_req_o(alrt),
        .therm_mon_en_o(mon), .therm_tmr_en_o(tmr), .dyn_tmin_en_o(tmin),
        .shutdown_en_o(shdn)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic fans(input logic ef, input logic eo, input logic en, input string tag);
        chk(full, ef, {tag, " fans_full"});
        chk(off, eo, {tag, " fans_off"});
        chk(norm, en, {tag, " defaults_norm"});
    endtask

    // Reset with given rail and strap; returns at a negedge, rst_n released.
    task automatic do_reset(input logic rg, input logic st);
        rst_n = 1'b0; rail_good = rg; strap = st; bus_hit = 1'b0;
        rail_low = 1'b0; sclr = 1'b0; alert_en = 1'b0;
        repeat (2) @(negedge clk);
        fans(st, !st, 1'b0, "R1 in reset");
        chk(sts, 1'b0, "R1 status");
        chk(mon & tmr & tmin & shdn, 1'b1, "R1 enables");
        rst_n = 1'b1;
        #1 fans(st, !st, 1'b0, "R1 check state");
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R2, R3, R4, R6, R7: transaction at edge j, both straps.
        for (int s = 0; s < 2; s++) begin
            for (int j = 2; j <= T + 4; j++) begin
                do_reset(1'b1, s[0]);
                for (int e = 1; e <= T + 6; e++) begin
                    logic pre, ef, eo;
                    bus_hit = (e == j);
                    step();
                    pre = (e < j) && (e < T + 1);
                    ef  = ((e >= T + 1) && (e < j)) || (pre && s[0]);
                    eo  = pre && !s[0];
                    fans(ef, eo, e >= j, (j <= T + 1) ? "R3 sweep" :
                         (s == 0 ? "R2 R4 sweep" : "R6 sweep"));
                end
                bus_hit = 1'b0;
            end
        end

        // R5: rail down, no deadline; rail rises later and starts the countdown.
        do_reset(1'b0, 1'b0);
        for (int e = 1; e <= 3 * T; e++) begin
            step();
            fans(1'b0, 1'b1, 1'b0, "R5 waiting no deadline");
        end
        rail_good = 1'b1;
        for (int k = 1; k <= T; k++) begin
            step();
            fans(1'b0, 1'b1, 1'b0, "R5 countdown after rise");
        end
        step();
        fans(1'b1, 1'b0, 1'b0, "R5 forced after countdown");
        bus_hit = 1'b1;
        step();
        bus_hit = 1'b0;
        fans(1'b0, 1'b0, 1'b1, "R4 release from forced");

        // R8: normal ignores further transactions and rail changes.
        for (int k = 0; k < 8; k++) begin
            bus_hit = k[0];
            rail_good = k[1];
            step();
            fans(1'b0, 1'b0, 1'b1, "R8 normal sticky");
        end
        bus_hit = 1'b0;

        // R5: a transaction at the same edge the rail rises takes priority.
        do_reset(1'b0, 1'b0);
        step();
        rail_good = 1'b1; bus_hit = 1'b1;
        step();
        bus_hit = 1'b0;
        fans(1'b0, 1'b0, 1'b1, "R5 hit beats rail rise");

        // R9, R10, R11: mixed low-rail sequence against a model.
        do_reset(1'b1, 1'b0);
        begin
            logic m_sts = 1'b0;
            for (int p = 0; p < 256; p++) begin
                for (int e = 0; e < 4; e++) begin
                    logic lo, cl;
                    lo = p[2*e];
                    cl = p[2*e+1];
                    rail_low = lo; sclr = cl;
                    alert_en = p[0] ^ e[0];
                    step();
                    m_sts = lo | (m_sts & ~cl);
                    chk(sts, m_sts, "R9 status");
                    chk(alrt, m_sts & alert_en, "R10 alert");
                    chk(mon, !lo, "R11 monitor enable");
                    chk(tmr, !lo, "R11 timer enable");
                    chk(tmin, !lo, "R11 tmin enable");
                    chk(shdn, !lo, "R11 shutdown enable");
                    alert_en = ~alert_en;
                    #1 chk(alrt, m_sts & alert_en, "R10 alert no delay");
                end
            end
        end
        rail_low = 1'b0; sclr = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule